// File: doc/BRIEF.md
# Reset-Pin Debug-Link Discriminator

This block watches one active-low pin that serves two purposes. It is the hardware reset input of the chip, and it also carries a UART-style debug channel. The two uses are told apart only by how long the pin stays low. A very long low is a reset request. A low of moderate length, followed by a sync character, opens a debug session. Any shorter low is treated as ordinary serial data.

The pin is first brought into the clock domain and filtered against glitches. A counter then measures each low period. The low is compared with limits that are multiples of the current bit period. The bit period starts from a configured seed. Once a session opens, the block learns the real bit period by timing the falling edges of the sync character (0x55) and uses that value from then on.

The limits are wide enough to tolerate a clock that is about 5% off. This lets a low-accuracy internal oscillator do the timing.

Top module: `rstlink_discriminator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rst_pulse`, `rst_active`, `brk_strobe` and `link_active` are 0 and `meas_period` is 0.
- R2: The pin passes through a two-flop synchronizer and then a 3-sample filter. The filtered level changes only after the pin has held a new level for three consecutive samples, so a pulse of two cycles or less in either direction is rejected.
- R3: A filtered low that lasts fewer than 11 bit periods is ignored. It produces no `brk_strobe`, no `rst_pulse` and no change to `link_active`.
- R4: A filtered low that lasts from 11 to 30 bit periods, both bounds included, produces exactly one single-cycle `brk_strobe` after the pin returns high, and sets `link_active`.
- R5: A filtered low that lasts longer than 30 bit periods produces exactly one single-cycle `rst_pulse`, in the cycle the threshold is crossed. It then holds `rst_active` high until the pin returns high. It produces no `brk_strobe`, clears `link_active`, and discards any learned bit period.
- R6: After a break, the sync character 0x55 (sent LSB first, 1 start bit, 8 data bits, 1 stop bit) has five falling edges that span 8 bit cells. The span from the first of these edges to the fifth, divided by 8, is latched on `meas_period`, and `link_active` stays 1 from then on.
- R7: While the block is waiting for the sync character or measuring it, a gap of 20 bit periods with no falling edge sends it back to idle. This clears `link_active` and discards the learned period.
- R8: The 11-, 20- and 30-bit limits are computed from `cfg_bit_period` until a sync completes, and from the measured period after that. They fall back to `cfg_bit_period` after a reset request or a sync timeout.
- R9: `brk_strobe` and `rst_pulse` are never high for two consecutive cycles, and `meas_period` changes only while `link_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Shared reset / debug pin, active low, idle high |
| cfg_bit_period | input | PER_W | Seed bit period in clock cycles |
| rst_pulse | output | 1 | One-cycle hardware reset request |
| rst_active | output | 1 | High from the reset request until the pin is released |
| brk_strobe | output | 1 | One-cycle strobe when a valid break ends |
| meas_period | output | PER_W | Last bit period measured from a sync character |
| link_active | output | 1 | Debug session open |

## Verification
The filtered pin lags the pin by six cycles. As a result, `brk_strobe` rises seven cycles after the pin is released. `rst_pulse` rises seven cycles after the low has exceeded 30 bit periods. `meas_period` updates one cycle after the fifth sync falling edge reaches the filter output.

The bench does not wait for an exact cycle. It counts strobes at falling clock edges over a whole scenario and compares the totals. It reads levels only after a margin of at least twenty cycles beyond the due cycle. The reset-pulse position is checked against a window of a few cycles around 30 bit periods after the pin fell. The timeout is probed well inside and well outside its 20-bit window.

// File: rtl/rstlink_pkg.sv
package rstlink_pkg;

    localparam int unsigned BRK_MIN_BITS    = 11;
    localparam int unsigned RST_MAX_BITS    = 30;
    localparam int unsigned SYNC_TMO_BITS   = 20;
    localparam int unsigned SYNC_FALLS      = 5;
    localparam int unsigned SYNC_SPAN_SHIFT = 3;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_WAIT,
        LS_MEAS,
        LS_LINK
    } link_state_e;

    typedef struct packed {
        logic [31:0] brk_min;
        logic [31:0] rst_max;
        logic [31:0] sync_tmo;
    } limits_t;

    function automatic limits_t make_limits(input logic [31:0] per);
        limits_t l;
        l.brk_min  = per * BRK_MIN_BITS;
        l.rst_max  = per * RST_MAX_BITS;
        l.sync_tmo = per * SYNC_TMO_BITS;
        return l;
    endfunction

endpackage

// File: rtl/rstlink_pin_filter.sv
module rstlink_pin_filter #(
    parameter int unsigned TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_filt,
    output logic pin_fall,
    output logic pin_rise
);

    logic [1:0]      sync_q;
    logic [TAPS-1:0] win_q;
    logic            filt_q;
    logic            filt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_q <= 1'b1;
            filt_d <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], pin_raw};
            win_q  <= {win_q[TAPS-2:0], sync_q[1]};
            if (&win_q) begin
                filt_q <= 1'b1;
            end else if (~|win_q) begin
                filt_q <= 1'b0;
            end
            filt_d <= filt_q;
        end
    end

    assign pin_filt = filt_q;
    assign pin_fall = filt_d & ~filt_q;
    assign pin_rise = ~filt_d & filt_q;

endmodule

// File: rtl/rstlink_low_timer.sv
module rstlink_low_timer #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_filt,
    input  logic             pin_rise,
    input  logic [CNT_W-1:0] brk_min,
    input  logic [CNT_W-1:0] rst_max,
    output logic             brk_strobe,
    output logic             rst_pulse,
    output logic             rst_active
);

    logic [CNT_W-1:0] low_cnt;
    logic             cross_now;
    logic             brk_now;

    assign cross_now = !pin_filt && !rst_active && (low_cnt >= rst_max);
    assign brk_now   = pin_rise && !rst_active &&
                       (low_cnt >= brk_min) && (low_cnt <= rst_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt    <= '0;
            brk_strobe <= 1'b0;
            rst_pulse  <= 1'b0;
            rst_active <= 1'b0;
        end else begin
            brk_strobe <= brk_now;
            rst_pulse  <= cross_now;
            if (cross_now) begin
                rst_active <= 1'b1;
            end else if (pin_filt) begin
                rst_active <= 1'b0;
            end
            if (pin_filt) begin
                low_cnt <= '0;
            end else if (!(&low_cnt)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstlink_autobaud.sv
module rstlink_autobaud
    import rstlink_pkg::*;
#(
    parameter int unsigned PER_W = 16,
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_fall,
    input  logic             brk_strobe,
    input  logic             rst_pulse,
    input  logic [CNT_W-1:0] sync_tmo,
    output logic             link_active,
    output logic             meas_valid,
    output logic [PER_W-1:0] meas_period
);

    link_state_e      state_q;
    logic [CNT_W-1:0] gap_cnt;
    logic [CNT_W-1:0] span_cnt;
    logic [2:0]       falls_q;
    logic [CNT_W-1:0] span_total;
    logic             gap_expired;

    assign span_total  = span_cnt + 1'b1;
    assign gap_expired = (gap_cnt >= sync_tmo);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LS_IDLE;
            gap_cnt     <= '0;
            span_cnt    <= '0;
            falls_q     <= '0;
            link_active <= 1'b0;
            meas_valid  <= 1'b0;
            meas_period <= '0;
        end else if (rst_pulse) begin
            state_q     <= LS_IDLE;
            link_active <= 1'b0;
            meas_valid  <= 1'b0;
        end else if (brk_strobe) begin
            state_q     <= LS_WAIT;
            link_active <= 1'b1;
            gap_cnt     <= '0;
        end else begin
            unique case (state_q)
                LS_WAIT: begin
                    if (pin_fall) begin
                        state_q  <= LS_MEAS;
                        span_cnt <= '0;
                        falls_q  <= 3'd1;
                        gap_cnt  <= '0;
                    end else if (gap_expired) begin
                        state_q     <= LS_IDLE;
                        link_active <= 1'b0;
                        meas_valid  <= 1'b0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                LS_MEAS: begin
                    if (!(&span_cnt)) begin
                        span_cnt <= span_cnt + 1'b1;
                    end
                    if (pin_fall) begin
                        gap_cnt <= '0;
                        if (falls_q == 3'(SYNC_FALLS - 1)) begin
                            meas_period <= PER_W'(span_total >> SYNC_SPAN_SHIFT);
                            meas_valid  <= 1'b1;
                            state_q     <= LS_LINK;
                        end else begin
                            falls_q <= falls_q + 1'b1;
                        end
                    end else if (gap_expired) begin
                        state_q     <= LS_IDLE;
                        link_active <= 1'b0;
                        meas_valid  <= 1'b0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/rstlink_discriminator.sv
module rstlink_discriminator
    import rstlink_pkg::*;
#(
    parameter int unsigned PER_W     = 16,
    parameter int unsigned FILT_TAPS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_n,
    input  logic [PER_W-1:0] cfg_bit_period,
    output logic             rst_pulse,
    output logic             rst_active,
    output logic             brk_strobe,
    output logic [PER_W-1:0] meas_period,
    output logic             link_active
);

    localparam int unsigned CNT_W = PER_W + 6;

    logic             pin_filt;
    logic             pin_fall;
    logic             pin_rise;
    logic             meas_valid;
    logic [PER_W-1:0] active_per;
    limits_t          lim;
    logic [CNT_W-1:0] brk_min;
    logic [CNT_W-1:0] rst_max;
    logic [CNT_W-1:0] sync_tmo;

    assign active_per = meas_valid ? meas_period : cfg_bit_period;
    assign lim        = make_limits(32'(active_per));
    assign brk_min    = CNT_W'(lim.brk_min);
    assign rst_max    = CNT_W'(lim.rst_max);
    assign sync_tmo   = CNT_W'(lim.sync_tmo);

    rstlink_pin_filter #(
        .TAPS (FILT_TAPS)
    ) u_filter (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_n),
        .pin_filt (pin_filt),
        .pin_fall (pin_fall),
        .pin_rise (pin_rise)
    );

    rstlink_low_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .pin_filt   (pin_filt),
        .pin_rise   (pin_rise),
        .brk_min    (brk_min),
        .rst_max    (rst_max),
        .brk_strobe (brk_strobe),
        .rst_pulse  (rst_pulse),
        .rst_active (rst_active)
    );

    rstlink_autobaud #(
        .PER_W (PER_W),
        .CNT_W (CNT_W)
    ) u_baud (
        .clk         (clk),
        .rst         (rst),
        .pin_fall    (pin_fall),
        .brk_strobe  (brk_strobe),
        .rst_pulse   (rst_pulse),
        .sync_tmo    (sync_tmo),
        .link_active (link_active),
        .meas_valid  (meas_valid),
        .meas_period (meas_period)
    );

endmodule

// File: rtl/rstlink_checker.sv
module rstlink_checker #(
    parameter int unsigned PER_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_pulse,
    input logic             rst_active,
    input logic             brk_strobe,
    input logic [PER_W-1:0] meas_period,
    input logic             link_active
);

    a_r9_rst_pulse_single: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

    a_r9_brk_single: assert property (@(posedge clk) disable iff (rst)
        brk_strobe |=> !brk_strobe);

    a_r5_pulse_holds_level: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> rst_active);

    a_r5_pulse_drops_link: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !link_active);

    a_r5_no_brk_during_reset: assert property (@(posedge clk) disable iff (rst)
        brk_strobe |-> !rst_active);

    a_r4_brk_opens_link: assert property (@(posedge clk) disable iff (rst)
        brk_strobe |=> link_active);

    a_r9_period_moves_in_link: assert property (@(posedge clk) disable iff (rst)
        !$stable(meas_period) |-> link_active);

endmodule

bind rstlink_discriminator rstlink_checker #(
    .PER_W (PER_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rst_pulse   (rst_pulse),
    .rst_active  (rst_active),
    .brk_strobe  (brk_strobe),
    .meas_period (meas_period),
    .link_active (link_active)
);

// File: tb/tb_rstlink_discriminator.sv
`timescale 1ns/1ps
module tb_rstlink_discriminator;

    localparam int PER_W = 16;
    localparam int SEED  = 16;
    localparam int MEAS  = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pin_n = 1'b1;
    logic [PER_W-1:0] cfg_bit_period = PER_W'(SEED);
    logic             rst_pulse;
    logic             rst_active;
    logic             brk_strobe;
    logic [PER_W-1:0] meas_period;
    logic             link_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int brk_cnt = 0;
    int rst_cnt = 0;
    int rst_cyc = 0;
    int fall_cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rstlink_discriminator #(.PER_W(PER_W), .FILT_TAPS(3)) dut (
        .clk            (clk),
        .rst            (rst),
        .pin_n          (pin_n),
        .cfg_bit_period (cfg_bit_period),
        .rst_pulse      (rst_pulse),
        .rst_active     (rst_active),
        .brk_strobe     (brk_strobe),
        .meas_period    (meas_period),
        .link_active    (link_active)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && brk_strobe) brk_cnt <= brk_cnt + 1;
        if (!rst && rst_pulse) begin
            rst_cnt <= rst_cnt + 1;
            rst_cyc <= cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_low(input int n);
        @(negedge clk);
        pin_n = 1'b0;
        fall_cyc = cyc;
        repeat (n) @(negedge clk);
        pin_n = 1'b1;
    endtask

    task automatic send_sync(input int per);
        logic [7:0] ch;
        ch = 8'h55;
        @(negedge clk);
        pin_n = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            pin_n = ch[i];
            repeat (per) @(negedge clk);
        end
        pin_n = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    task automatic t_reset_state;
        check(rst_pulse == 1'b0, "R1 rst_pulse", int'(rst_pulse), 0);
        check(rst_active == 1'b0, "R1 rst_active", int'(rst_active), 0);
        check(brk_strobe == 1'b0, "R1 brk_strobe", int'(brk_strobe), 0);
        check(link_active == 1'b0, "R1 link_active", int'(link_active), 0);
        check(meas_period == '0, "R1 meas_period", int'(meas_period), 0);
    endtask

    task automatic t_glitch;
        int b0;
        int r0;
        b0 = brk_cnt;
        r0 = rst_cnt;
        send_low(2);
        idle(40);
        check(brk_cnt == b0, "R2 low glitch brk", brk_cnt - b0, 0);
        check(link_active == 1'b0, "R2 low glitch link", int'(link_active), 0);
        @(negedge clk);
        pin_n = 1'b0;
        idle(100);
        pin_n = 1'b1;
        idle(2);
        pin_n = 1'b0;
        idle(138);
        pin_n = 1'b1;
        idle(40);
        check(brk_cnt == b0 + 1, "R2 high glitch inside break", brk_cnt - b0, 1);
        check(rst_cnt == r0, "R2 no reset", rst_cnt - r0, 0);
        idle(800);
    endtask

    task automatic t_short_lows;
        int b0;
        b0 = brk_cnt;
        send_low(3 * SEED);
        idle(40);
        send_low(11 * SEED - 1);
        idle(40);
        check(brk_cnt == b0, "R3 short lows ignored", brk_cnt - b0, 0);
        check(link_active == 1'b0, "R3 link stays idle", int'(link_active), 0);
    endtask

    task automatic t_break_min_and_timeout;
        int b0;
        b0 = brk_cnt;
        send_low(11 * SEED);
        idle(40);
        check(brk_cnt == b0 + 1, "R4 break at 11 bits", brk_cnt - b0, 1);
        check(link_active == 1'b1, "R4 link opened", int'(link_active), 1);
        idle(20 * SEED - 60);
        check(link_active == 1'b1, "R7 still waiting inside window", int'(link_active), 1);
        idle(80);
        check(link_active == 1'b0, "R7 sync timeout clears link", int'(link_active), 0);
    endtask

    task automatic t_break_max;
        int b0;
        int r0;
        b0 = brk_cnt;
        r0 = rst_cnt;
        send_low(30 * SEED);
        idle(40);
        check(brk_cnt == b0 + 1, "R4 break at 30 bits", brk_cnt - b0, 1);
        check(rst_cnt == r0, "R4 no reset at 30 bits", rst_cnt - r0, 0);
        idle(800);
    endtask

    task automatic t_reset_request;
        int b0;
        int r0;
        b0 = brk_cnt;
        r0 = rst_cnt;
        send_low(30 * SEED + 1);
        idle(40);
        check(rst_cnt == r0 + 1, "R5 reset just over 30 bits", rst_cnt - r0, 1);
        check(brk_cnt == b0, "R5 no break with reset", brk_cnt - b0, 0);
        check(rst_active == 1'b0, "R5 released after high", int'(rst_active), 0);
        send_low(11 * SEED);
        idle(40);
        check(link_active == 1'b1, "R5 setup link open", int'(link_active), 1);
        b0 = brk_cnt;
        r0 = rst_cnt;
        @(negedge clk);
        pin_n = 1'b0;
        fall_cyc = cyc;
        idle(700);
        check(rst_active == 1'b1, "R5 level held while low", int'(rst_active), 1);
        check(rst_cnt == r0 + 1, "R5 single pulse", rst_cnt - r0, 1);
        check((rst_cyc - fall_cyc) >= 30 * SEED + 1 && (rst_cyc - fall_cyc) <= 30 * SEED + 10,
              "R5 pulse position", rst_cyc - fall_cyc, 30 * SEED + 7);
        check(link_active == 1'b0, "R5 link cleared", int'(link_active), 0);
        idle(1300);
        pin_n = 1'b1;
        idle(30);
        check(rst_active == 1'b0, "R5 level drops on release", int'(rst_active), 0);
        check(rst_cnt == r0 + 1, "R5 still one pulse", rst_cnt - r0, 1);
        check(brk_cnt == b0, "R5 no break after long low", brk_cnt - b0, 0);
    endtask

    task automatic open_session;
        send_low(20 * SEED);
        idle(2 * SEED);
        send_sync(MEAS);
        idle(30);
    endtask

    task automatic t_autobaud;
        open_session();
        check(meas_period == PER_W'(MEAS), "R6 measured period", int'(meas_period), MEAS);
        check(link_active == 1'b1, "R6 link active after sync", int'(link_active), 1);
        idle(1000);
        check(link_active == 1'b1, "R6 link persists", int'(link_active), 1);
    endtask

    task automatic t_measured_limits;
        int b0;
        int r0;
        b0 = brk_cnt;
        r0 = rst_cnt;
        send_low(11 * MEAS - 1);
        idle(40);
        check(brk_cnt == b0, "R8 measured break floor", brk_cnt - b0, 0);
        send_low(30 * SEED + 20);
        idle(40);
        check(brk_cnt == b0 + 1, "R8 measured reset ceiling gives break", brk_cnt - b0, 1);
        check(rst_cnt == r0, "R8 no reset under measured ceiling", rst_cnt - r0, 0);
        idle(800);
        check(link_active == 1'b0, "R7 timeout after re-break", int'(link_active), 0);
        send_low(200);
        idle(40);
        check(brk_cnt == b0 + 2, "R8 seed limits after timeout", brk_cnt - b0, 2);
        idle(800);
        open_session();
        check(meas_period == PER_W'(MEAS), "R6 second measurement", int'(meas_period), MEAS);
        r0 = rst_cnt;
        b0 = brk_cnt;
        send_low(30 * MEAS + 1);
        idle(40);
        check(rst_cnt == r0 + 1, "R8 reset over measured ceiling", rst_cnt - r0, 1);
        send_low(200);
        idle(40);
        check(brk_cnt == b0 + 1, "R8 seed limits after reset", brk_cnt - b0, 1);
        idle(800);
    endtask

    initial begin
        idle(10);
        t_reset_state();
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        idle(20);
        t_glitch();
        t_short_lows();
        t_break_min_and_timeout();
        t_break_max();
        t_reset_request();
        t_autobaud();
        t_measured_limits();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule